// File: doc/BRIEF.md
# Wraparound Accumulator with Overflow Tracking

This block adds a stream of signed two's complement words into an accumulator of fixed width that is free to wrap. For each accepted word it reports the new wrapped sum, and one cycle after the word it reports whether that step overflowed. An overflow is detected by comparing the carry into the sign bit of the adder with the carry out of it. The overflow on a single step is not treated as an error.

Each overflow also updates an internal signed wrap counter. The counter goes up on a positive overflow and down on a negative one. When the word marked as the last of a frame is accepted, the block latches a final-valid flag. The flag is set only when the up-wraps and the down-wraps of the whole frame cancel. In that case the true frame sum fits in the word, so the wrapped result equals it exactly. The next accepted word then starts a new frame from zero.

The intended user sums blocks of samples into a narrow register and only needs the final result to be exact. Width planning follows the usual rule: m words of b bits need b + log2(m) bits to never overflow. This block lets a narrower word be used, and it tells at the end of the frame whether that was safe.

Top module: `wrap_acc`

## Requirements
- R1: While rst_ni is low, and after it is released, sum_o is 0, ovf_o is 0 and final_valid_o is 0 until the first word is accepted.
- R2: A word is accepted when in_valid_i is high at a clock edge. After that edge, sum_o equals the previous sum plus in_data_i, modulo 2^DATA_W. At the start of a frame the previous sum is taken as 0.
- R3: After an accepted word, ovf_o is 1 for exactly that cycle if the step overflowed, and 0 otherwise. A step overflows when the carry into the sign bit differs from the carry out of it. This happens when two non-negative operands give a negative result, or two negative operands give a non-negative result.
- R4: With in_valid_i low, sum_o holds its value, ovf_o is 0, and in_last_i has no effect on any output or on frame state.
- R5: When a word is accepted with in_last_i high, final_valid_o is set one cycle later. It is 1 if the true integer sum of the frame lies in [-2^(DATA_W-1), 2^(DATA_W-1)-1], and 0 otherwise. At 4 bits, the frame 6, 7, -7 yields 1 and the frame 6, 7, -5 yields 0.
- R6: After the last word of a frame, sum_o keeps showing the final wrapped sum until the next word is accepted. That next word starts a new frame with a sum of zero and a wrap count of zero.
- R7: final_valid_o keeps its value until the next last word is accepted.
- R8: A frame of a single word, with in_valid_i and in_last_i high together, gives sum_o equal to that word, ovf_o equal to 0 and final_valid_o equal to 1.
- R9: Intermediate overflows that cancel within a frame of up to MAX_FRAME words still give final_valid_o equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word qualifier |
| in_data_i | input | DATA_W | Signed two's complement input word |
| in_last_i | input | 1 | Marks the accepted word as the last of its frame |
| sum_o | output | DATA_W | Running wrapped sum |
| ovf_o | output | 1 | Overflow flag for the previous step |
| final_valid_o | output | 1 | Latched frame result: the final sum is exact |

## Verification
Two events can land on the same cycle. The first is an overflow on the last word of a frame. There, the wrap counter update and the final-valid decision have to use the same step. The directed frames 6, 7, -7 and 6, 7, -5 cause exactly this: a negative overflow and no overflow on the closing word. The bench judges the result against a model that keeps the frame sum as a plain integer.

The second pairing is a frame close followed at once by the first word of the next frame. It checks that the clear of the sum and of the counter does not drop or double-count that word. Random stimulus sets valid and last freely, so these pairings occur many times.

// File: rtl/wrap_acc_pkg.sv
package wrap_acc_pkg;
  typedef struct packed {
    logic up;   // positive overflow
    logic down; // negative overflow
  } wrap_t;
endpackage

// File: rtl/wrap_add.sv
module wrap_add
  import wrap_acc_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o,
  output wrap_t             wrap_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] low;
  logic [1:0]        top;
  logic              c_sign_in;
  logic              c_sign_out;

  always_comb begin
    low        = {1'b0, a_i[MSB-1:0]} + {1'b0, b_i[MSB-1:0]};
    c_sign_in  = low[MSB];
    top        = {1'b0, a_i[MSB]} + {1'b0, b_i[MSB]} + {1'b0, c_sign_in};
    c_sign_out = top[1];
    sum_o      = {top[0], low[MSB-1:0]};
    // carries differ: invalid step; carry-out tells direction
    wrap_o.up   = (c_sign_in ^ c_sign_out) & ~c_sign_out;
    wrap_o.down = (c_sign_in ^ c_sign_out) &  c_sign_out;
  end
endmodule

// File: rtl/wrap_cnt.sv
module wrap_cnt
  import wrap_acc_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             restart_i,
  input  wrap_t            wrap_i,
  output logic [CNT_W-1:0] cnt_next_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;

  always_comb begin
    base = restart_i ? '0 : cnt_q;
    if (wrap_i.up)        cnt_next_o = base + CNT_W'(1);
    else if (wrap_i.down) cnt_next_o = base - CNT_W'(1);
    else                  cnt_next_o = base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_next_o;
  end
endmodule

// File: rtl/wrap_acc.sv
module wrap_acc
  import wrap_acc_pkg::*;
#(
  parameter int DATA_W    = 4,
  parameter int MAX_FRAME = 256
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  input  logic [DATA_W-1:0] in_data_i,
  input  logic              in_last_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              ovf_o,
  output logic              final_valid_o
);
  // signed range must hold +/-MAX_FRAME wraps
  localparam int CNT_W = $clog2(MAX_FRAME + 1) + 1;

  logic [DATA_W-1:0] acc_q;
  logic              start_q;
  logic              ovf_q;
  logic              fin_q;
  logic [DATA_W-1:0] base;
  logic [DATA_W-1:0] add_sum;
  wrap_t             wrap;
  logic [CNT_W-1:0]  cnt_next;

  assign base = start_q ? '0 : acc_q;

  wrap_add #(.DATA_W(DATA_W)) u_add (
    .a_i    (base),
    .b_i    (in_data_i),
    .sum_o  (add_sum),
    .wrap_o (wrap)
  );

  wrap_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (in_valid_i),
    .restart_i  (start_q),
    .wrap_i     (wrap),
    .cnt_next_o (cnt_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      start_q <= 1'b1;
      ovf_q   <= 1'b0;
      fin_q   <= 1'b0;
    end else begin
      ovf_q <= in_valid_i & (wrap.up | wrap.down);
      if (in_valid_i) begin
        acc_q   <= add_sum;
        start_q <= in_last_i;
        if (in_last_i) fin_q <= (cnt_next == '0);
      end
    end
  end

  assign sum_o         = acc_q;
  assign ovf_o         = ovf_q;
  assign final_valid_o = fin_q;
endmodule

// File: rtl/wrap_acc_chk.sv
module wrap_acc_chk #(
  parameter int DATA_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic [DATA_W-1:0] in_data_i,
  input logic              in_last_i,
  input logic [DATA_W-1:0] sum_o,
  input logic              ovf_o,
  input logic              final_valid_o,
  input logic              start_q
);
  localparam int MSB = DATA_W - 1;

  a_r2_sum_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !start_q |=> sum_o == DATA_W'($past(sum_o) + $past(in_data_i)));

  a_r3_pos_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !start_q && !sum_o[MSB] && !in_data_i[MSB] |=> ovf_o == sum_o[MSB]);

  a_r3_neg_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && !start_q && sum_o[MSB] && in_data_i[MSB] |=> ovf_o == !sum_o[MSB]);

  a_r3_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && (start_q || (sum_o[MSB] != in_data_i[MSB])) |=> !ovf_o);

  a_r4_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !ovf_o && $stable(sum_o));

  a_r7_fin_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_valid_i && in_last_i) |=> $stable(final_valid_o));

  a_r8_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_last_i && start_q |=> final_valid_o && sum_o == $past(in_data_i));
endmodule

bind wrap_acc wrap_acc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .in_valid_i    (in_valid_i),
  .in_data_i     (in_data_i),
  .in_last_i     (in_last_i),
  .sum_o         (sum_o),
  .ovf_o         (ovf_o),
  .final_valid_o (final_valid_o),
  .start_q       (start_q)
);

// File: tb/tb_wrap_acc.sv
`timescale 1ns/1ps
module tb_wrap_acc;
  localparam int W  = 4;
  localparam int LO = -(1 << (W - 1));
  localparam int HI = (1 << (W - 1)) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic [W-1:0] dat = '0;
  logic         lst = 1'b0;
  logic [W-1:0] sum;
  logic         ovf;
  logic         fin;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  int m_sum = 0, m_true = 0;
  bit m_start = 1, m_fin = 0, m_ovf = 0;
  int m_len = 0;

  always #2 clk = ~clk;

  wrap_acc #(.DATA_W(W), .MAX_FRAME(256)) dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(vld), .in_data_i(dat),
    .in_last_i(lst), .sum_o(sum), .ovf_o(ovf), .final_valid_o(fin)
  );

  function automatic int sx(logic [W-1:0] v);
    return v[W-1] ? int'(v) - (1 << W) : int'(v);
  endfunction

  function automatic int wrapv(int v);
    return sx(W'(v));
  endfunction

  function automatic bit fits(int v);
    return (v >= LO) && (v <= HI);
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // called at negedge: drive, advance one cycle, compare at next negedge
  task automatic step(bit v, int d, bit l, string req);
    int t;
    vld = v; dat = W'(d); lst = l;
    m_ovf = 0;
    if (v) begin
      t      = (m_start ? 0 : m_sum) + d;
      m_ovf  = !fits(t);
      m_sum  = wrapv(t);
      m_true = (m_start ? 0 : m_true) + d;
      if (l) m_fin = fits(m_true);
      m_start = l;
    end
    @(negedge clk);
    chk({req, " sum"}, sx(sum), m_sum);
    chk({req, " ovf"}, int'(ovf), int'(m_ovf));
    chk({req, " fin"}, int'(fin), int'(m_fin));
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int d;
    bit v, l;
    process::self().srandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset sum", sx(sum), 0);
    chk("R1 reset ovf", int'(ovf), 0);
    chk("R1 reset fin", int'(fin), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release sum", sx(sum), 0);
    chk("R1 release fin", int'(fin), 0);

    // R5/R9: cancelling wrap, then a non-cancelling one (same-cycle ovf+close)
    step(1, 6, 0, "R2");
    step(1, 7, 0, "R3");
    step(1, -7, 1, "R5 R9 6,7,-7");
    chk("R5 valid frame", int'(fin), 1);
    step(1, 6, 0, "R6 restart");
    step(1, 7, 0, "R3");
    step(1, -5, 1, "R5 6,7,-5");
    chk("R5 invalid frame", int'(fin), 0);
    // R4: idle with last high must not close or change anything
    step(0, 3, 1, "R4 idle last");
    step(0, -8, 0, "R4 idle");
    chk("R6 final sum held", sx(sum), -8);
    // R8: single-word frame, back to back with next frame
    step(1, 7, 1, "R8 single");
    step(1, -8, 1, "R8 single neg");
    step(1, -8, 0, "R6 back-to-back");
    step(1, -8, 0, "R3 neg wrap");
    step(0, 0, 0, "R7 hold");
    step(1, 5, 1, "R5 close");

    for (int i = 0; i < 3000; i++) begin
      v = ($urandom % 4) != 0;
      d = int'($urandom % (1 << W)) + LO;
      l = ($urandom % 8) == 0;
      if (v && !m_start) m_len++;
      if (v && m_start) m_len = 1;
      if (m_len >= 40) l = 1;
      step(v, d, l, "R2 R3 R5 R7 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule